// File: doc/BRIEF.md
# Prescaled Interval and Match Timer Channel

This block is one 16-bit timer counter channel. A free-running clock-domain counter advances on ticks. Ticks come either on every clock or, with the divider switched on, once per 2^(N+1) clocks. The counter counts up or down. In free-run mode it wraps over the full 16-bit range. In interval mode it wraps over the range 0 to a programmed top value. Three compare values are checked against the count on every step. A sticky six-bit status vector records wraps and compare hits. A level interrupt is raised whenever a status bit and its mask bit are both set.

Control and configuration arrive as plain register values from a host-side register file. Two single-cycle strobes act on the channel: one zeroes the counter, the other clears the status vector. A two-state machine gates counting. `ST_HALT` is the reset state and is held while the disable input is high. `ST_RUN` is entered on the clock after disable goes low. The transition `HALT_TO_RUN` is taken when disable is low, and `RUN_TO_HALT` is taken when disable is high. The state register follows the disable input with one clock of latency. While halted, the prescaler phase is held at zero.

Top module: `timer_chan`

## Requirements
- R1: After reset the count is 0, the status vector is 0, irq is low and the channel is in `ST_HALT`.
- R2: While the channel is in `ST_HALT`, the count does not change (except by the clear strobe) and the prescaler phase is held at zero. `ST_RUN` is entered on the clock after `cfg_disable` is sampled low.
- R3: Counting up in free-run mode, each tick adds one. A tick at 0xFFFF gives 0 and sets status bit 4 (overflow).
- R4: Counting up in interval mode, a tick at a count greater than or equal to `interval_top` gives 0 and sets status bit 0 (interval). Status bit 4 is not set.
- R5: Counting down, each tick subtracts one. A tick at 0 reloads the top value: `interval_top` in interval mode, which sets status bit 0, or 0xFFFF in free-run mode, which sets status bit 4.
- R6: With `cfg_presc_en` high, a tick occurs once every 2^(`cfg_presc_sel`+1) clocks of `ST_RUN`. With it low, a tick occurs on every clock of `ST_RUN`.
- R7: The `cnt_clear` strobe makes the count 0 on the next clock and restarts the prescaler phase. It overrides a tick in the same cycle, and that suppressed tick sets no status.
- R8: With `cfg_match_en` high, compare i (i = 0, 1, 2) sets status bit i+1 on a tick whose resulting count equals `match_val[i]`, including a count reached by a wrap. With `cfg_match_en` low, compares set nothing.
- R9: Status bits are sticky. `sts_clear` zeroes all of them on the next clock, but a bit set in that same cycle stays set.
- R10: `irq` is high exactly when `status & irq_mask` is nonzero, in the same cycle as the status or mask change.
- R11: Status bit 5 (external event) is never set by this channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_disable | input | 1 | High halts counting |
| cfg_interval_mode | input | 1 | 1 = wrap at `interval_top`, 0 = full 16-bit range |
| cfg_count_down | input | 1 | 1 = decrement, 0 = increment |
| cfg_match_en | input | 1 | Enables the three compares |
| cnt_clear | input | 1 | One-cycle strobe that zeroes the count and prescaler phase |
| cfg_presc_en | input | 1 | Enables the power-of-two divider |
| cfg_presc_sel | input | 4 | Divider exponent N; the divide ratio is 2^(N+1) |
| interval_top | input | 16 | Highest count in interval mode |
| match_val | input | 3x16 | Compare values, index 0..2 |
| irq_mask | input | 6 | Per-status-bit interrupt enable |
| sts_clear | input | 1 | One-cycle strobe that clears all status bits |
| count | output | 16 | Current count |
| status | output | 6 | bit0 interval wrap, bits1-3 compare hits, bit4 overflow, bit5 event |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the wrap edges in both directions and both modes. Among these is the step from 0 down to 0xFFFF, and a wrong-mode design would set bit 0 there instead of bit 4. It also drives a compare on value 0 that is reached only through a wrap, which a design comparing the pre-step count would miss. It lines up a status clear with a wrap in the same cycle, where a clear-wins design would lose the event. It also checks the one-clock start-up latency and the restart of the prescaler phase on clear, both of which a design with an off-by-one divider would shift by whole ticks.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int unsigned STS_IVL_BIT   = 0;
    localparam int unsigned STS_MATCH_LSB = 1;

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             presc_en,
    input  logic [SEL_W-1:0] presc_sel,
    output logic             tick
);
    localparam int unsigned PRE_W = (1 << SEL_W) + 1;

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = (PRE_W'(1) << (int'(presc_sel) + 1)) - PRE_W'(1);
        tick  = run && (!presc_en || (phase_q >= limit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
    import timer_chan_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_disable,
    input  logic             cfg_interval_mode,
    input  logic             cfg_count_down,
    input  logic [CNT_W-1:0] interval_top,
    input  logic             cnt_clear,
    input  logic             tick,
    output logic             run,
    output logic             step,
    output logic             wrap,
    output logic [CNT_W-1:0] next_count,
    output logic [CNT_W-1:0] count
);
    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] top_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (!cfg_disable) state_d = ST_RUN;   // HALT_TO_RUN
            ST_RUN:  if (cfg_disable)  state_d = ST_HALT;  // RUN_TO_HALT
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  run = 1'b1;
            ST_HALT: run = 1'b0;
            default: run = 1'b0;
        endcase
    end

    always_comb begin
        top_val    = cfg_interval_mode ? interval_top : {CNT_W{1'b1}};
        step       = tick && !cnt_clear;
        wrap       = 1'b0;
        next_count = count_q;
        if (cfg_count_down) begin
            if (count_q == '0) begin
                next_count = top_val;
                wrap       = step;
            end else begin
                next_count = count_q - CNT_W'(1);
            end
        end else begin
            if (count_q >= top_val) begin
                next_count = '0;
                wrap       = step;
            end else begin
                next_count = count_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_clear) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= next_count;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/timer_match_bank.sv
module timer_match_bank #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned NUM_MATCH = 3
) (
    input  logic                            step,
    input  logic                            match_en,
    input  logic [CNT_W-1:0]                next_count,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] match_val,
    output logic [NUM_MATCH-1:0]            hit
);
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
        assign hit[i] = step && match_en && (next_count == match_val[i]);
    end

endmodule

// File: rtl/timer_status.sv
module timer_status
    import timer_chan_pkg::*;
#(
    parameter int unsigned NUM_MATCH = 3,
    localparam int unsigned STS_W    = NUM_MATCH + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wrap,
    input  logic                 interval_mode,
    input  logic [NUM_MATCH-1:0] hit,
    input  logic                 sts_clear,
    input  logic [STS_W-1:0]     irq_mask,
    output logic [STS_W-1:0]     status,
    output logic                 irq
);
    localparam int unsigned OVF_BIT = NUM_MATCH + 1;

    logic [STS_W-1:0] sts_q;
    logic [STS_W-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        set_vec[STS_MATCH_LSB +: NUM_MATCH] = hit;
        if (wrap) begin
            if (interval_mode) set_vec[STS_IVL_BIT] = 1'b1;
            else               set_vec[OVF_BIT]     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_clear ? '0 : sts_q) | set_vec;
        end
    end

    assign status = sts_q;
    assign irq    = |(sts_q & irq_mask);

endmodule

// File: rtl/timer_chan.sv
module timer_chan #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned NUM_MATCH = 3,
    localparam int unsigned STS_W    = NUM_MATCH + 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_disable,
    input  logic                            cfg_interval_mode,
    input  logic                            cfg_count_down,
    input  logic                            cfg_match_en,
    input  logic                            cnt_clear,
    input  logic                            cfg_presc_en,
    input  logic [SEL_W-1:0]                cfg_presc_sel,
    input  logic [CNT_W-1:0]                interval_top,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] match_val,
    input  logic [STS_W-1:0]                irq_mask,
    input  logic                            sts_clear,
    output logic [CNT_W-1:0]                count,
    output logic [STS_W-1:0]                status,
    output logic                            irq
);
    logic                 run;
    logic                 tick;
    logic                 step;
    logic                 wrap;
    logic [CNT_W-1:0]     next_count;
    logic [NUM_MATCH-1:0] hit;

    timer_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (cnt_clear),
        .presc_en  (cfg_presc_en),
        .presc_sel (cfg_presc_sel),
        .tick      (tick)
    );

    timer_count_core #(.CNT_W(CNT_W)) u_core (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_disable       (cfg_disable),
        .cfg_interval_mode (cfg_interval_mode),
        .cfg_count_down    (cfg_count_down),
        .interval_top      (interval_top),
        .cnt_clear         (cnt_clear),
        .tick              (tick),
        .run               (run),
        .step              (step),
        .wrap              (wrap),
        .next_count        (next_count),
        .count             (count)
    );

    timer_match_bank #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_match (
        .step       (step),
        .match_en   (cfg_match_en),
        .next_count (next_count),
        .match_val  (match_val),
        .hit        (hit)
    );

    timer_status #(.NUM_MATCH(NUM_MATCH)) u_sts (
        .clk           (clk),
        .rst_n         (rst_n),
        .wrap          (wrap),
        .interval_mode (cfg_interval_mode),
        .hit           (hit),
        .sts_clear     (sts_clear),
        .irq_mask      (irq_mask),
        .status        (status),
        .irq           (irq)
    );

endmodule

// File: rtl/timer_chan_chk.sv
module timer_chan_chk #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned NUM_MATCH = 3,
    localparam int unsigned STS_W    = NUM_MATCH + 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_interval_mode,
    input logic             cfg_count_down,
    input logic             cfg_match_en,
    input logic             cnt_clear,
    input logic             sts_clear,
    input logic [CNT_W-1:0] interval_top,
    input logic [CNT_W-1:0] count,
    input logic [STS_W-1:0] status,
    input logic             run,
    input logic             tick
);
    localparam int unsigned OVF_BIT = NUM_MATCH + 1;

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_clear) |=> (count == $past(count)));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (count == '0));

    // R9
    sticky_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_clear |=> ((status & $past(status)) == $past(status)));

    // R8
    match_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_match_en && !sts_clear) |=>
            (status[NUM_MATCH:1] == $past(status[NUM_MATCH:1])));

    // R4
    ivl_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_clear && !cfg_count_down && cfg_interval_mode &&
         count >= interval_top) |=> (count == '0 && status[0]));

    // R5
    down_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_clear && cfg_count_down && !cfg_interval_mode &&
         count == '0) |=> (count == {CNT_W{1'b1}} && status[OVF_BIT]));

endmodule

bind timer_chan timer_chan_chk #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cfg_interval_mode (cfg_interval_mode),
    .cfg_count_down    (cfg_count_down),
    .cfg_match_en      (cfg_match_en),
    .cnt_clear         (cnt_clear),
    .sts_clear         (sts_clear),
    .interval_top      (interval_top),
    .count             (count),
    .status            (status),
    .run               (run),
    .tick              (tick)
);

// File: tb/tb_timer_chan.sv
`timescale 1ns/100ps
module tb_timer_chan;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_disable = 1'b1;
    logic            cfg_interval_mode = 1'b0;
    logic            cfg_count_down = 1'b0;
    logic            cfg_match_en = 1'b0;
    logic            cnt_clear = 1'b0;
    logic            cfg_presc_en = 1'b0;
    logic [3:0]      cfg_presc_sel = 4'd0;
    logic [15:0]     interval_top = 16'd0;
    logic [2:0][15:0] match_val = '0;
    logic [5:0]      irq_mask = 6'd0;
    logic            sts_clear = 1'b0;
    logic [15:0]     count;
    logic [5:0]      status;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_run = 0;
    int m_pre = 0;
    int m_cnt = 0;
    int m_sts = 0;

    always #2.5 clk = ~clk;

    timer_chan dut (
        .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable),
        .cfg_interval_mode(cfg_interval_mode), .cfg_count_down(cfg_count_down),
        .cfg_match_en(cfg_match_en), .cnt_clear(cnt_clear),
        .cfg_presc_en(cfg_presc_en), .cfg_presc_sel(cfg_presc_sel),
        .interval_top(interval_top), .match_val(match_val),
        .irq_mask(irq_mask), .sts_clear(sts_clear),
        .count(count), .status(status), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_pre = 0; m_cnt = 0; m_sts = 0;
        end else begin
            int top, lim, nc, setv, tk;
            top  = cfg_interval_mode ? int'(interval_top) : 65535;
            lim  = (1 << (int'(cfg_presc_sel) + 1)) - 1;
            tk   = (m_run != 0) && (!cfg_presc_en || m_pre >= lim);
            setv = 0;
            nc   = m_cnt;
            if (tk && !cnt_clear) begin
                if (cfg_count_down) begin
                    if (m_cnt == 0) begin
                        nc = top;
                        setv |= cfg_interval_mode ? 1 : 16;
                    end else nc = m_cnt - 1;
                end else begin
                    if (m_cnt >= top) begin
                        nc = 0;
                        setv |= cfg_interval_mode ? 1 : 16;
                    end else nc = m_cnt + 1;
                end
                for (int i = 0; i < 3; i++)
                    if (cfg_match_en && nc == int'(match_val[i])) setv |= (2 << i);
            end
            if (cnt_clear) nc = 0;
            if (m_run == 0 || cnt_clear || tk) m_pre = 0;
            else m_pre = m_pre + 1;
            m_sts = (sts_clear ? 0 : m_sts) | setv;
            m_cnt = nc;
            m_run = cfg_disable ? 0 : 1;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 R4 R5 R6 count vs model", int'(count), m_cnt);
            check("R8 R9 R11 status vs model", int'(status), m_sts);
            check("R10 irq vs model", int'(irq), ((m_sts & int'(irq_mask)) != 0) ? 1 : 0);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check("R1 count", int'(count), 0);
        check("R1 status", int'(status), 0);
        check("R1 irq", int'(irq), 0);

        // R3 free-run up, first tick one clock after enable
        cfg_disable = 1'b0;
        cycles(10);
        check("R3 count after start", int'(count), 9);

        // R7 clear overrides tick
        cnt_clear = 1'b1; cfg_count_down = 1'b1;
        cycles(1);
        check("R7 count cleared", int'(count), 0);
        check("R7 no status", int'(status), 0);
        cnt_clear = 1'b0;
        cycles(1);
        // R5 free-run down wrap
        check("R5 down wrap count", int'(count), 16'hFFFF);
        check("R5 overflow bit", int'(status), 6'h10);
        // R10 mask
        check("R10 irq masked", int'(irq), 0);
        irq_mask = 6'h10; #1;
        check("R10 irq unmasked", int'(irq), 1);
        irq_mask = 6'h00;
        sts_clear = 1'b1; cfg_disable = 1'b1;
        cycles(1);
        check("R9 status cleared", int'(status), 0);
        sts_clear = 1'b0;
        c0 = int'(count);
        cycles(5);
        check("R2 halted count holds", int'(count), c0);

        // R3 up wrap from 0xFFFF with same-cycle clear (R9 set wins)
        cnt_clear = 1'b1;
        cycles(1);
        cnt_clear = 1'b0; cfg_disable = 1'b0;
        cycles(2);
        check("R5 reach FFFF", int'(count), 16'hFFFF);
        cfg_count_down = 1'b0; sts_clear = 1'b1;
        cycles(1);
        sts_clear = 1'b0;
        check("R3 up wrap count", int'(count), 0);
        check("R9 set wins over clear", int'(status), 6'h10);

        // R4 interval up
        cfg_interval_mode = 1'b1; interval_top = 16'd4;
        cnt_clear = 1'b1; sts_clear = 1'b1;
        cycles(1);
        cnt_clear = 1'b0; sts_clear = 1'b0;
        cycles(4);
        check("R4 at top", int'(count), 4);
        check("R4 no wrap yet", int'(status), 0);
        cycles(1);
        check("R4 wrapped", int'(count), 0);
        check("R4 interval bit", int'(status), 6'h01);

        // R5 interval down
        cfg_count_down = 1'b1; cnt_clear = 1'b1; sts_clear = 1'b1;
        cycles(1);
        cnt_clear = 1'b0; sts_clear = 1'b0;
        cycles(1);
        check("R5 reload top", int'(count), 4);
        check("R5 interval bit", int'(status), 6'h01);

        // R6 prescaler divide by 4
        cfg_count_down = 1'b0; cfg_interval_mode = 1'b0;
        cfg_presc_en = 1'b1; cfg_presc_sel = 4'd1; cnt_clear = 1'b1;
        cycles(1);
        cnt_clear = 1'b0;
        cycles(7);
        check("R6 one tick", int'(count), 1);
        cycles(1);
        check("R6 two ticks", int'(count), 2);

        // R8 compares, including value reached by wrap
        cfg_presc_en = 1'b0; cfg_interval_mode = 1'b1; interval_top = 16'd9;
        match_val[0] = 16'd3; match_val[1] = 16'd7; match_val[2] = 16'd0;
        cfg_match_en = 1'b1; cnt_clear = 1'b1; sts_clear = 1'b1;
        cycles(1);
        cnt_clear = 1'b0; sts_clear = 1'b0;
        cycles(3);
        check("R8 first compare", int'(status), 6'h02);
        cycles(7);
        check("R8 wrap count", int'(count), 0);
        check("R8 all compares", int'(status), 6'h0F);
        cfg_match_en = 1'b0; sts_clear = 1'b1;
        cycles(1);
        sts_clear = 1'b0;
        cycles(10);
        check("R8 compares disabled", int'(status), 6'h01);

        irq_mask = 6'h01; #1;
        check("R10 irq on bit0", int'(irq), 1);
        irq_mask = 6'h3E; #1;
        check("R10 irq off", int'(irq), 0);
        check("R11 event bit clear", int'(status[5]), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule